// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

This block joins two independently clocked ports, A and B, with two first-in first-out queues that run in opposite directions. The forward queue accepts words written at port A and delivers them to reads at port B. The return queue accepts words written at port B and delivers them to reads at port A. Each queue is 36 bits wide and 512 words deep by default. Each port has its own clock, a direction select, an enable, a request strobe, an address field and separate write and read data buses.

A port cycle reaches its queue only when the port's whole address field is high, and enable and request are both high on the port's rising clock edge. Each queue returns a full flag to the port that writes it. The flag is raised by the writer's rising edge. A read first releases the freed location on the falling edge of the reader's clock. The writer's full flag then drops on a later writer rising edge, after the released pointer has crossed a short synchronizer.

The block suits links between two processing domains that exchange streams in both directions. Queue pointers cross between the clocks in Gray code.

Top module: `bififo_pair`

## Requirements
- R1: After the asynchronous reset (`rst_n` low), both full flags are low, both read data buses are zero and both queues are empty.
- R2: A port A cycle takes effect only on a rising `a_clk` edge with `a_en`=1, `a_req`=1 and `a_addr`=3'b111. Any other address, or a low enable or request, stores nothing and leaves `a_rdata` unchanged.
- R3: A port B cycle takes effect only on a rising `b_clk` edge with `b_en`=1, `b_req`=1 and `b_addr[0]`=1. Otherwise it stores nothing and leaves `b_rdata` unchanged.
- R4: A valid cycle with the direction select at 1 (1 = write, 0 = read) stores the write data word when the queue's full flag is low.
- R5: A valid cycle with the direction select at 0 on a non-empty queue places the oldest stored word on the port's read bus right after that edge. The bus then holds the word until the next accepted read.
- R6: Each queue returns words in the order written: port A to port B for the forward queue, and port B to port A for the return queue. The two queues do not affect each other.
- R7: The full flag rises just after the writer rising edge that stores the word making DEPTH words held. It is low while fewer than DEPTH words are held and the pointers have settled.
- R8: A write while the full flag is high is ignored, and the queue contents and order stay unchanged.
- R9: After a read from a full queue, the writer's full flag stays high until a writer rising edge that follows the reader's next falling edge. It then drops within SYNC_STAGES+2 writer rising edges of that falling edge.
- R10: A read from an empty queue is ignored, and the read bus keeps its previous value.
- R11: The number of words held never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| a_clk | input | 1 | Port A clock |
| a_rw | input | 1 | Port A direction select: 1 writes the forward queue, 0 reads the return queue |
| a_en | input | 1 | Port A enable |
| a_req | input | 1 | Port A request strobe |
| a_addr | input | 3 | Port A address; all ones selects queue access |
| a_wdata | input | 36 | Port A write word |
| a_rdata | output | 36 | Port A read word from the return queue |
| a_full | output | 1 | Forward queue full, in the port A domain |
| b_clk | input | 1 | Port B clock |
| b_rw | input | 1 | Port B direction select: 1 writes the return queue, 0 reads the forward queue |
| b_en | input | 1 | Port B enable |
| b_req | input | 1 | Port B request strobe |
| b_addr | input | 1 | Port B address; 1 selects queue access |
| b_wdata | input | 36 | Port B write word |
| b_rdata | output | 36 | Port B read word from the forward queue |
| b_full | output | 1 | Return queue full, in the port B domain |

## Verification
A corrupted write or read pointer shows up as a word out of order or a repeated word on the read bus at the very next accepted read. A miscounted fill level shows as a full flag that is wrong on the cycle after the DEPTH-th write, or as a rejected word that later appears in the drained stream. A broken release path shows as a full flag that drops before the reader's falling edge can have reached the writer, or one that is still high four writer edges later.

// File: rtl/bififo_pkg.sv
package bififo_pkg;

   // direction select encoding shared by both ports
   typedef enum logic {
      XFER_READ  = 1'b0,
      XFER_WRITE = 1'b1
   } xfer_dir_e;

   localparam int WORD_W_DEFAULT  = 36;
   localparam int DEPTH_DEFAULT   = 512;
   localparam int SYNC_DEFAULT    = 2;

endpackage

// File: rtl/bififo_sync.sv
module bififo_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_width
      $error("bififo_sync: W must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("bififo_sync: STAGES must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/bififo_decode.sv
module bififo_decode
   import bififo_pkg::*;
#(
   parameter int AW = 3
) (
   input  logic          rw,
   input  logic          en,
   input  logic          req,
   input  logic [AW-1:0] addr,
   output logic          wr_hit,
   output logic          rd_hit
);

   if (AW < 1) begin : g_bad_aw
      $error("bififo_decode: AW must be at least 1");
   end

   logic sel;

   // queue access needs every address bit high plus enable and request
   assign sel    = en & req & (&addr);
   assign wr_hit = sel & (rw == XFER_WRITE);
   assign rd_hit = sel & (rw == XFER_READ);

endmodule

// File: rtl/bififo_lane.sv
module bififo_lane #(
   parameter int DATA_W      = 36,
   parameter int DEPTH       = 512,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rst_n,
   input  logic              wclk,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wdata,
   output logic              full,
   input  logic              rclk,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rdata
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("bififo_lane: DEPTH must be a power of two, at least 4");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("bififo_lane: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bififo_lane: SYNC_STAGES must be at least 2");
   end

   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [DATA_W-1:0] mem [DEPTH];

   // ---------------- writer domain ----------------
   logic [PW-1:0] wbin, wgray, wbin_nxt, wgray_nxt;
   logic [PW-1:0] rgray_w;
   logic          full_q, full_nxt, wr_do;

   assign wr_do     = wr_req & ~full_q;
   assign wbin_nxt  = wbin + PW'(wr_do);
   assign wgray_nxt = to_gray(wbin_nxt);
   // full: equal pointers except the two top Gray bits inverted
   assign full_nxt  = (wgray_nxt == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin   <= '0;
         wgray  <= '0;
         full_q <= 1'b0;
      end else begin
         wbin   <= wbin_nxt;
         wgray  <= wgray_nxt;
         full_q <= full_nxt;
      end
   end

   always_ff @(posedge wclk) begin
      if (wr_do) mem[wbin[AW-1:0]] <= wdata;
   end

   assign full = full_q;

   // ---------------- reader domain ----------------
   logic [PW-1:0] rbin, rgray, rbin_nxt;
   logic [PW-1:0] rgray_pub, wgray_r;
   logic [DATA_W-1:0] rdata_q;
   logic          empty, rd_do;

   assign empty    = (rgray == wgray_r);
   assign rd_do    = rd_req & ~empty;
   assign rbin_nxt = rbin + PW'(rd_do);

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rgray   <= '0;
         rdata_q <= '0;
      end else begin
         rbin  <= rbin_nxt;
         rgray <= to_gray(rbin_nxt);
         if (rd_do) rdata_q <= mem[rbin[AW-1:0]];
      end
   end

   // freed locations are released toward the writer on the falling edge
   always_ff @(negedge rclk or negedge rst_n) begin
      if (!rst_n) rgray_pub <= '0;
      else        rgray_pub <= rgray;
   end

   assign rdata = rdata_q;

   // ---------------- crossings ----------------
   bififo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk   (wclk),
      .rst_n (rst_n),
      .d     (rgray_pub),
      .q     (rgray_w)
   );

   bififo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk   (rclk),
      .rst_n (rst_n),
      .d     (wgray),
      .q     (wgray_r)
   );

   // ---------------- assertions ----------------
   // R8
   full_write_blocked_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      (full_q && wr_req) |=> $stable(wbin));

   // R7
   full_rise_cause_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      $rose(full_q) |-> $past(wr_do));

   // R11
   occupancy_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      (wbin - from_gray(rgray_w)) <= PW'(DEPTH));

   // R10
   empty_read_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      (rd_req && empty) |=> $stable(rdata_q));

   // R5
   rdata_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      !rd_do |=> $stable(rdata_q));

endmodule

// File: rtl/bififo_pair.sv
module bififo_pair
   import bififo_pkg::*;
#(
   parameter int DATA_W      = WORD_W_DEFAULT,
   parameter int DEPTH       = DEPTH_DEFAULT,
   parameter int SYNC_STAGES = SYNC_DEFAULT,
   parameter int A_ADDR_W    = 3,
   parameter int B_ADDR_W    = 1
) (
   input  logic                rst_n,
   input  logic                a_clk,
   input  logic                a_rw,
   input  logic                a_en,
   input  logic                a_req,
   input  logic [A_ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0]   a_wdata,
   output logic [DATA_W-1:0]   a_rdata,
   output logic                a_full,
   input  logic                b_clk,
   input  logic                b_rw,
   input  logic                b_en,
   input  logic                b_req,
   input  logic [B_ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0]   b_wdata,
   output logic [DATA_W-1:0]   b_rdata,
   output logic                b_full
);

   if (A_ADDR_W < 1 || B_ADDR_W < 1) begin : g_bad_addr
      $error("bififo_pair: address widths must be at least 1");
   end

   logic a_wr_hit, a_rd_hit, b_wr_hit, b_rd_hit;

   bififo_decode #(.AW(A_ADDR_W)) u_dec_a (
      .rw     (a_rw),
      .en     (a_en),
      .req    (a_req),
      .addr   (a_addr),
      .wr_hit (a_wr_hit),
      .rd_hit (a_rd_hit)
   );

   bififo_decode #(.AW(B_ADDR_W)) u_dec_b (
      .rw     (b_rw),
      .en     (b_en),
      .req    (b_req),
      .addr   (b_addr),
      .wr_hit (b_wr_hit),
      .rd_hit (b_rd_hit)
   );

   // forward queue: written at A, read at B
   bififo_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_fwd (
      .rst_n  (rst_n),
      .wclk   (a_clk),
      .wr_req (a_wr_hit),
      .wdata  (a_wdata),
      .full   (a_full),
      .rclk   (b_clk),
      .rd_req (b_rd_hit),
      .rdata  (b_rdata)
   );

   // return queue: written at B, read at A
   bififo_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ret (
      .rst_n  (rst_n),
      .wclk   (b_clk),
      .wr_req (b_wr_hit),
      .wdata  (b_wdata),
      .full   (b_full),
      .rclk   (a_clk),
      .rd_req (a_rd_hit),
      .rdata  (a_rdata)
   );

   // R2
   a_miss_no_read_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
      !(a_en && a_req && (&a_addr)) |=> $stable(a_rdata));

   // R3
   b_miss_no_read_chk: assert property (@(posedge b_clk) disable iff (!rst_n)
      !(b_en && b_req && (&b_addr)) |=> $stable(b_rdata));

endmodule

// File: tb/sim_bififo_pair.sv
module sim_bififo_pair;

   localparam int DW    = 36;
   localparam int DEPTH = 512;
   localparam int SYNC  = 2;

   logic          rst_n;
   logic          a_clk = 0, b_clk = 0;
   logic          a_rw, a_en, a_req;
   logic [2:0]    a_addr;
   logic [DW-1:0] a_wdata, a_rdata;
   logic          a_full;
   logic          b_rw, b_en, b_req;
   logic [0:0]    b_addr;
   logic [DW-1:0] b_wdata, b_rdata;
   logic          b_full;

   always #5 a_clk = ~a_clk;   // 100 MHz
   always #7 b_clk = ~b_clk;

   bififo_pair #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(SYNC)) u0 (
      .rst_n(rst_n),
      .a_clk(a_clk), .a_rw(a_rw), .a_en(a_en), .a_req(a_req), .a_addr(a_addr),
      .a_wdata(a_wdata), .a_rdata(a_rdata), .a_full(a_full),
      .b_clk(b_clk), .b_rw(b_rw), .b_en(b_en), .b_req(b_req), .b_addr(b_addr),
      .b_wdata(b_wdata), .b_rdata(b_rdata), .b_full(b_full)
   );

   // behavioural reference: one queue per direction plus last word read
   logic [DW-1:0] q_fwd [$];
   logic [DW-1:0] q_ret [$];
   logic [DW-1:0] a_last, b_last;
   int checks = 0, fails = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic a_op(input logic rw, input logic en, input logic req,
                       input logic [2:0] addr, input logic [DW-1:0] d, input string tag);
      bit hit;
      @(negedge a_clk);
      a_rw = rw; a_en = en; a_req = req; a_addr = addr; a_wdata = d;
      @(negedge a_clk);
      hit = en && req && (addr == 3'b111);
      if (hit && rw && q_fwd.size() < DEPTH) q_fwd.push_back(d);
      if (hit && !rw && q_ret.size() > 0) a_last = q_ret.pop_front();
      a_en = 0; a_req = 0;
      if (!rw) chk(tag, a_rdata, a_last);
   endtask

   task automatic b_op(input logic rw, input logic en, input logic req,
                       input logic addr, input logic [DW-1:0] d, input string tag);
      bit hit;
      @(negedge b_clk);
      b_rw = rw; b_en = en; b_req = req; b_addr = addr; b_wdata = d;
      @(negedge b_clk);
      hit = en && req && addr;
      if (hit && rw && q_ret.size() < DEPTH) q_ret.push_back(d);
      if (hit && !rw && q_fwd.size() > 0) b_last = q_fwd.pop_front();
      b_en = 0; b_req = 0;
      if (!rw) chk(tag, b_rdata, b_last);
   endtask

   task automatic settle();
      repeat (12) @(negedge b_clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int k;
      rst_n = 0;
      a_rw = 0; a_en = 0; a_req = 0; a_addr = 0; a_wdata = 0;
      b_rw = 0; b_en = 0; b_req = 0; b_addr = 0; b_wdata = 0;
      a_last = '0; b_last = '0;
      #33 rst_n = 1;
      #2;
      // R1 reset state
      chk("R1 a_full", {35'd0, a_full}, '0);
      chk("R1 b_full", {35'd0, b_full}, '0);
      chk("R1 a_rdata", a_rdata, '0);
      chk("R1 b_rdata", b_rdata, '0);
      settle();

      // R10 read from empty queues
      b_op(0, 1, 1, 1'b1, '0, "R10 b empty read");
      a_op(0, 1, 1, 3'b111, '0, "R10 a empty read");

      // R2 misses on port A must store nothing
      a_op(1, 1, 1, 3'b110, 36'h0_DEAD_0001, "R2 miss addr");
      a_op(1, 1, 1, 3'b011, 36'h0_DEAD_0002, "R2 miss addr");
      a_op(1, 0, 1, 3'b111, 36'h0_DEAD_0003, "R2 no enable");
      a_op(1, 1, 0, 3'b111, 36'h0_DEAD_0004, "R2 no request");
      // R4 valid writes
      a_op(1, 1, 1, 3'b111, 36'h1_1111_1111, "R4 write");
      a_op(1, 1, 1, 3'b111, 36'h2_2222_2222, "R4 write");
      a_op(1, 1, 1, 3'b111, 36'hF_0000_0003, "R4 write");
      settle();
      // R3 port B miss read leaves bus alone
      b_op(0, 1, 1, 1'b0, '0, "R3 b miss read");
      // R5 R6 ordered delivery, then R10 extra read holds
      b_op(0, 1, 1, 1'b1, '0, "R5 R6 fwd read 1");
      b_op(0, 1, 1, 1'b1, '0, "R6 fwd read 2");
      b_op(0, 1, 1, 1'b1, '0, "R6 fwd read 3");
      b_op(0, 1, 1, 1'b1, '0, "R10 fwd read empty");

      // return direction
      b_op(1, 1, 1, 1'b0, 36'h0_BAD0_0001, "R3 b miss write");
      b_op(1, 0, 1, 1'b1, 36'h0_BAD0_0002, "R3 b no enable");
      b_op(1, 1, 1, 1'b1, 36'hA_5A5A_5A5A, "R4 b write");
      b_op(1, 1, 1, 1'b1, 36'h5_A5A5_A5A5, "R4 b write");
      settle();
      a_op(0, 1, 1, 3'b101, '0, "R2 a miss read");
      a_op(0, 1, 1, 3'b111, '0, "R6 ret read 1");
      a_op(0, 1, 1, 3'b111, '0, "R6 ret read 2");
      a_op(0, 1, 1, 3'b111, '0, "R10 ret read empty");
      settle();

      // R7 fill the forward queue
      for (int i = 0; i < DEPTH - 1; i++)
         a_op(1, 1, 1, 3'b111, {4'h7, 32'(i)}, "R7 fill");
      chk("R7 not full at DEPTH-1", {35'd0, a_full}, '0);
      a_op(1, 1, 1, 3'b111, {4'h7, 32'(DEPTH - 1)}, "R7 fill last");
      chk("R7 full at DEPTH", {35'd0, a_full}, 36'd1);
      chk("R6 other flag independent", {35'd0, b_full}, '0);

      // R8 writes while full are dropped
      a_op(1, 1, 1, 3'b111, 36'hE_EEEE_EEEE, "R8 write full");
      a_op(1, 1, 1, 3'b111, 36'hE_EEEE_EEEF, "R8 write full");
      chk("R8 still full", {35'd0, a_full}, 36'd1);

      // R9 release timing
      b_op(0, 1, 1, 1'b1, '0, "R9 read from full");
      chk("R9 no early clear", {35'd0, a_full}, 36'd1);
      k = 0;
      for (int n = 1; n <= 8; n++) begin
         @(posedge a_clk); #2;
         if (!a_full) begin k = n; break; end
      end
      checks++;
      if (k < 1 || k > SYNC + 2) begin
         fails++;
         $display("FAIL R9 clear edges actual=%0d expected=1..%0d", k, SYNC + 2);
      end
      settle();
      a_op(1, 1, 1, 3'b111, 36'hC_0000_0C0C, "R4 refill");
      settle();
      chk("R7 full again", {35'd0, a_full}, 36'd1);

      // R8 R6 drain and confirm rejected words never appear
      for (int i = 0; i < DEPTH; i++)
         b_op(0, 1, 1, 1'b1, '0, "R8 R6 drain");
      settle();
      chk("R9 empty not full", {35'd0, a_full}, '0);
      b_op(0, 1, 1, 1'b1, '0, "R10 drained read");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule